// File: doc/BRIEF.md
# Programmable Down-Counter Timer

A 32-bit down-counter for a processor register bus. Software loads a start value into a reload register, then issues a start command through the control register. The count then runs down. In timer mode it steps once per system clock. In event mode it steps once per rising edge of an external input, which the block synchronises to its own clock.

Each time the count is stepped while it already reads zero, the block does three things: it reloads the count from the reload register, raises a sticky status flag, and toggles the timer output pin. With a reload value of N, the output therefore toggles once every N+1 steps. The flag drives an interrupt request when the interrupt is enabled. Reading the status register clears the flag.

The bus is a plain register port with a single-cycle write strobe and a read strobe. Read data is combinational from the address, so no back-pressure exists. The read strobe matters only for the side effect of clearing the status flag.

Top module: `cnt_timer_periph`

## Requirements
- R1: After reset, the count, reload, control and status registers all read 0, the timer output is 0, the interrupt request is 0, and the counter is halted.
- R2: Register index 0 holds the reload value and can be read and written. Index 1 returns the live count and ignores writes.
- R3: The control register is at index 2. A write with bit 7 (start) set and bit 6 (stop) clear loads the count from the reload value at that clock edge and sets the counter running. A write with bit 6 set halts the counter and holds the count; stop wins when both bits are set. Each control write also stores bit 0 (mode) and bit 1 (interrupt enable). On read, bits 0 and 1 return the stored values and every other bit returns 0.
- R4: When running with mode = 1 (timer), a non-zero count decrements by one at every clock edge.
- R5: With mode = 0 (event), the external input passes through two synchroniser flops, and only a rising edge counts. A rise first sampled high at clock edge k steps the count at edge k+2. A level held high steps the count only once.
- R6: A step taken while the count is 0 does three things: it loads the reload value, sets the zero flag, and toggles the timer output. The timer output changes at no other time.
- R7: The status register is at index 3, with bit 0 as the zero flag. The flag stays set until a read strobe at index 3. If a new zero event happens in the same cycle as that read, the flag stays set.
- R8: The interrupt request is high exactly while the zero flag is set and control bit 1 is 1.
- R9: While halted, neither clocks nor external events change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect: clears the status flag) |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_in | input | 1 | External event input, asynchronous |
| tmr_out | output | 1 | Toggles at every zero event |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at four corner cases:
- A reload value of 0, where every step is a zero event. A design that reaches zero one step early or late would show the wrong toggle period.
- A status read that coincides with a new zero event. A design that lets the clear win would lose an interrupt.
- A long high level on the event input. A design that counts levels rather than edges would step the count more than once.
- A stop issued while the counter is running in either mode, followed by further clocks and events. A leaky halt would drift the held count.

A cycle-accurate behavioural model catches any off-by-one in the synchroniser latency.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STAT   = 2'd3
  } reg_idx_e;

  localparam int CTL_MODE  = 0;
  localparam int CTL_IE    = 1;
  localparam int CTL_STOP  = 6;
  localparam int CTL_START = 7;
  localparam int STAT_ZERO = 0;
  localparam int BYTE_W    = 8;
endpackage

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  output logic evt_rise
);
  localparam int PIPE_W = STAGES + 1;

  // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous value
  logic [PIPE_W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= evt_in;
      for (int i = 1; i < PIPE_W; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign evt_rise = pipe[STAGES-1] & ~pipe[STAGES];

  // R5: a rising edge yields a single-cycle step request
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rise |=> !evt_rise);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             mode_timer,
  input  logic             evt_rise,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             tmr_out,
  output logic             zero_hit
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             tout_q;
  logic             step;

  assign step     = run_q & (mode_timer | evt_rise) & ~start & ~stop;
  assign zero_hit = step & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      if (stop) begin
        run_q <= 1'b0;
      end else if (start) begin
        run_q <= 1'b1;
        cnt_q <= reload;
      end else if (step) begin
        cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
      end
      if (zero_hit) tout_q <= ~tout_q;
    end
  end

  assign cnt     = cnt_q;
  assign tmr_out = tout_q;

  // R6: the output pin moves only on a zero event
  a_r6_tout_only_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_hit |=> $stable(tout_q));
  // R6: a zero event leaves the reload value in the count
  a_r6_reload_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> (cnt_q == $past(reload)));
  // R9: a halted counter holds its value unless restarted
  a_r9_hold_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             zero_hit,
  output logic [CNT_W-1:0] reload_val,
  output logic             mode_timer,
  output logic             start_cmd,
  output logic             stop_cmd,
  output logic             irq
);
  localparam int PAD_W = CNT_W - BYTE_W;

  logic [CNT_W-1:0]  reload_q;
  logic              mode_q;
  logic              ie_q;
  logic              flag_q;
  logic              wr_ctrl;
  logic              rd_stat;
  logic [BYTE_W-1:0] ctrl_byte;
  logic [BYTE_W-1:0] stat_byte;

  assign wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
  assign rd_stat   = bus_rd && (bus_addr == REG_STAT);
  assign stop_cmd  = wr_ctrl & bus_wdata[CTL_STOP];
  assign start_cmd = wr_ctrl & bus_wdata[CTL_START] & ~bus_wdata[CTL_STOP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      mode_q   <= 1'b0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (bus_wr && (bus_addr == REG_RELOAD)) reload_q <= bus_wdata;
      if (wr_ctrl) begin
        mode_q <= bus_wdata[CTL_MODE];
        ie_q   <= bus_wdata[CTL_IE];
      end
      if (zero_hit)     flag_q <= 1'b1;
      else if (rd_stat) flag_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_byte            = '0;
    ctrl_byte[CTL_MODE]  = mode_q;
    ctrl_byte[CTL_IE]    = ie_q;
    stat_byte            = '0;
    stat_byte[STAT_ZERO] = flag_q;
  end

  always_comb begin
    case (bus_addr)
      REG_RELOAD: bus_rdata = reload_q;
      REG_COUNT:  bus_rdata = cnt_val;
      REG_CTRL:   bus_rdata = {{PAD_W{1'b0}}, ctrl_byte};
      default:    bus_rdata = {{PAD_W{1'b0}}, stat_byte};
    endcase
  end

  assign reload_val = reload_q;
  assign mode_timer = mode_q;
  assign irq        = flag_q & ie_q;

  // R7: the flag holds until a status read
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !rd_stat) |=> flag_q);
  // R7: a zero event is never lost to a simultaneous read
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> flag_q);
endmodule

// File: rtl/cnt_timer_periph.sv
module cnt_timer_periph #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             evt_in,
  output logic             tmr_out,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] reload_val;
  logic             zero_hit;
  logic             mode_timer;
  logic             start_cmd;
  logic             stop_cmd;
  logic             evt_rise;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_val(cnt_val), .zero_hit(zero_hit), .reload_val(reload_val),
    .mode_timer(mode_timer), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .irq(irq)
  );

  tmr_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .evt_rise(evt_rise)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start_cmd), .stop(stop_cmd),
    .mode_timer(mode_timer), .evt_rise(evt_rise), .reload(reload_val),
    .cnt(cnt_val), .tmr_out(tmr_out), .zero_hit(zero_hit)
  );
endmodule

// File: tb/test_cnt_timer_periph.sv
`timescale 1ns/100ps
module test_cnt_timer_periph;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        evt_in = 1'b0;
  logic        tmr_out;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  cnt_timer_periph i_cnt_timer_periph (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .tmr_out(tmr_out), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_rel, m_cnt;
  logic m_run, m_mode, m_ie, m_flag, m_tout;
  logic [2:0] m_evt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rel = 0; m_cnt = 0; m_run = 0; m_mode = 0; m_ie = 0;
      m_flag = 0; m_tout = 0; m_evt = 0;
    end else begin
      bit rise, wc, st, sp, stp, hit;
      rise = m_evt[1] && !m_evt[2];
      wc   = bus_wr && bus_addr == 2'd2;
      sp   = wc && bus_wdata[6];
      st   = wc && bus_wdata[7] && !bus_wdata[6];
      stp  = m_run && (m_mode || rise) && !st && !sp;
      hit  = stp && m_cnt == 0;
      if (sp) m_run = 0;
      else if (st) begin m_run = 1; m_cnt = m_rel; end
      else if (stp) m_cnt = hit ? m_rel : m_cnt - 1;
      if (hit) begin m_flag = 1; m_tout = !m_tout; end
      else if (bus_rd && bus_addr == 2'd3) m_flag = 0;
      if (wc) begin m_mode = bus_wdata[0]; m_ie = bus_wdata[1]; end
      if (bus_wr && bus_addr == 2'd0) m_rel = bus_wdata;
      m_evt = {m_evt[1:0], evt_in};
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] e;
      string t;
      case (bus_addr)
        2'd0: begin e = m_rel; t = "R2 model reload"; end
        2'd1: begin e = m_cnt; t = "R4 model count"; end
        2'd2: begin e = {30'd0, m_ie, m_mode}; t = "R3 model ctrl"; end
        default: begin e = {31'd0, m_flag}; t = "R7 model status"; end
      endcase
      check(t, bus_rdata, e);
      check("R6 model tmr_out", {31'd0, tmr_out}, {31'd0, m_tout});
      check("R8 model irq", {31'd0, irq}, {31'd0, m_flag & m_ie});
    end
  end

  // all tasks start and end 0.5 ns after a rising edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #0.5;
    bus_wr = 0; bus_wdata = 0;
  endtask
  task automatic peek(input logic [1:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; #2.5;
    check(tag, bus_rdata, exp);
    @(posedge clk); #0.5;
  endtask
  task automatic rdclr(input logic [31:0] exp, input string tag);
    bus_addr = 2'd3; bus_rd = 1; #2.5;
    check(tag, bus_rdata, exp);
    @(posedge clk); #0.5;
    bus_rd = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #0.5; end
  endtask
  task automatic pulse(input int hi, input int lo);
    evt_in = 1; idle(hi);
    evt_in = 0; idle(lo);
  endtask

  initial begin
    #80000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic t0;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    // R1 reset state
    check("R1 tmr_out", {31'd0, tmr_out}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    peek(2'd1, 0, "R1 count");
    peek(2'd0, 0, "R1 reload");
    peek(2'd2, 0, "R1 ctrl");
    peek(2'd3, 0, "R1 status");
    // R2 reload rw, count ignores writes
    wr(2'd0, 32'd5);
    peek(2'd0, 5, "R2 reload readback");
    wr(2'd1, 32'd123);
    peek(2'd1, 0, "R2 count write ignored");
    // R3 start timer mode, R4 decrement
    wr(2'd2, 32'h81);
    peek(2'd1, 5, "R3 start loads reload");
    peek(2'd2, 32'h01, "R3 ctrl readback cmd bits zero");
    peek(2'd1, 3, "R4 decrement per clock");
    idle(3);
    // R6 zero event
    check("R6 tmr_out toggled", {31'd0, tmr_out}, 1);
    check("R8 irq masked", {31'd0, irq}, 0);
    peek(2'd1, 5, "R6 reload after zero");
    peek(2'd3, 1, "R7 flag set");
    wr(2'd2, 32'h41);
    idle(4);
    peek(2'd1, 3, "R9 held after stop");
    rdclr(1, "R7 read before clear");
    peek(2'd3, 0, "R7 cleared by read");
    // R8 interrupt
    wr(2'd2, 32'h83);
    idle(7);
    check("R8 irq asserted", {31'd0, irq}, 1);
    rdclr(1, "R7 status read");
    check("R8 irq drops", {31'd0, irq}, 0);
    wr(2'd2, 32'h42);
    // R7 set beats clear with reload 0
    wr(2'd0, 32'd0);
    wr(2'd2, 32'h81);
    idle(2);
    rdclr(1, "R7 read during zero");
    peek(2'd3, 1, "R7 set wins over clear");
    wr(2'd2, 32'h40);
    rdclr(1, "R7 clear");
    // R5 event mode
    wr(2'd0, 32'd2);
    wr(2'd2, 32'h82);
    peek(2'd1, 2, "R5 loaded");
    pulse(3, 3);
    peek(2'd1, 1, "R5 one edge one step");
    pulse(10, 3);
    peek(2'd1, 0, "R5 long level one step");
    t0 = tmr_out;
    pulse(3, 3);
    check("R6 event zero toggles", {31'd0, tmr_out}, {31'd0, ~t0});
    peek(2'd1, 2, "R6 event reload");
    check("R8 irq event mode", {31'd0, irq}, 1);
    // R9 events while halted
    wr(2'd2, 32'h40);
    pulse(3, 3);
    pulse(3, 3);
    peek(2'd1, 2, "R9 events ignored when halted");
    idle(5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule